// File: doc/BRIEF.md
# Crosspoint Switch Two-Rank Configuration Port

This block is the parallel control port of a crosspoint switch with 33 inputs and 17 outputs. Every output has a 7-bit configuration word. Bit 6 of the word enables the output. Bits 5:0 give the number of the input that feeds that output. The words live in two ranks of storage. The host loads the first rank one output at a time. A single update strobe then moves all 17 words into the second rank at once. Only the second rank drives the switch fabric, so a complete new routing takes effect in one step.

The host sees a 5-bit output address, an active-low chip select, and active-low write, read, update and reset lines. The bidirectional data pins are modelled as two separate paths:

- an input path for words the host writes;
- an output path with its own drive-enable, used for readback of second-rank words.

The reset line is a global output kill. It is asynchronous and is not gated by chip select. It clears the enable bit of every second-rank word and leaves the select fields and the whole first rank as they were.

Top module: `xbar_cfg_port`

## Requirements
- R1: A write happens on a rising clock edge while `csN` and `weN` are both low and `addr` is below 17. It captures `dataIn` into the first-rank word of that output. The outputs do not change until an update.
- R2: A rising edge with `csN` and `updN` both low copies all 17 first-rank words into the second rank. If a write happens in the same edge, the copy takes the first-rank contents from before that write.
- R3: While `csN` and `reN` are both low, `dataOe` is 1 and `dataOut` carries the second-rank word of output `addr`, laid out as {enable at bit 6, select at bits 5:0}. Otherwise `dataOe` is 0.
- R4: A write in the same cycle as a readback does not change the word being read back. Readback always shows the second rank.
- R5: While `csN` is high, write and update strobes have no effect on either rank or on any output.
- R6: A write to an address from 17 to 31 changes nothing. A readback of such an address returns 0.
- R7: While `rstN` is low, every bit of `enVec` is 0 at once, without a clock edge and whatever `csN` is. The second-rank select fields and the first rank keep their contents.
- R8: `enVec[i]` is bit 6 of the second-rank word of output i. `selVec[6*i+5:6*i]` is its bits 5:0.
- R9: `badSel[i]` is 1 exactly when the second-rank select field of output i is greater than 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all storage |
| rstN | input | 1 | Asynchronous active-low global output disable |
| csN | input | 1 | Active-low chip select for the host port |
| weN | input | 1 | Active-low write strobe |
| reN | input | 1 | Active-low readback strobe |
| updN | input | 1 | Active-low rank transfer strobe |
| addr | input | 5 | Output address |
| dataIn | input | 7 | Word written by the host |
| dataOut | output | 7 | Readback word |
| dataOe | output | 1 | Drive-enable for the readback word |
| selVec | output | 102 | Select field of each output, 6 bits per output |
| enVec | output | 17 | Enable bit of each output |
| badSel | output | 17 | Out-of-range select flag of each output |

## Verification
The case that is hardest to reach from the ports is a reset that clears the enables while both ranks still hold meaningful data. Checking it requires showing that the first rank survived, even though the first rank cannot be read directly. The stimulus first loads a varied routing and transfers it. It then pulls reset low with chip select high and checks the outputs between clock edges. After releasing reset it issues a plain update. The enables must then come back exactly as they were loaded, which is the only view of the first rank the ports allow. A write and an update in the same edge is reached in a similar way: a second update afterwards exposes whichever word the first copy missed.

// File: rtl/xcfg_pkg.sv
`timescale 1ns/1ps
package xcfg_pkg;
  typedef struct packed {
    logic wrStb;
    logic xferStb;
    logic rdStb;
    logic addrOk;
  } cfgStrobes_t;
endpackage

// File: rtl/xcfg_ctrl.sv
`timescale 1ns/1ps
module xcfg_ctrl #(
  parameter int NUM_OUT = 17,
  parameter int ADDR_W  = 5
) (
  input  logic                 csN,
  input  logic                 weN,
  input  logic                 reN,
  input  logic                 updN,
  input  logic [ADDR_W-1:0]    addr,
  output xcfg_pkg::cfgStrobes_t stb
);
  // Chip select gates every host action; reset is handled in the datapath.
  always_comb begin
    stb.wrStb   = !csN && !weN;
    stb.xferStb = !csN && !updN;
    stb.rdStb   = !csN && !reN;
    stb.addrOk  = (32'(addr) < NUM_OUT);
  end
endmodule

// File: rtl/xcfg_store.sv
`timescale 1ns/1ps
module xcfg_store #(
  parameter int NUM_OUT = 17,
  parameter int NUM_IN  = 33,
  parameter int ADDR_W  = 5,
  parameter int WORD_W  = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xcfg_pkg::cfgStrobes_t       stb,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           dataIn,
  output logic [WORD_W-1:0]           dataOut,
  output logic                        dataOe,
  output logic [NUM_OUT*(WORD_W-1)-1:0] selVec,
  output logic [NUM_OUT-1:0]          enVec,
  output logic [NUM_OUT-1:0]          badSel
);
  localparam int SEL_W = WORD_W - 1;
  localparam int IDX_W = $clog2(NUM_OUT);
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_IN - 1);

  logic [NUM_OUT-1:0][SEL_W-1:0] selR1, selR2;
  logic [NUM_OUT-1:0]            enR1, enR2;
  logic [IDX_W-1:0]              idx;
  logic [WORD_W-1:0]             rdWord;

  assign idx = IDX_W'(addr);

  // First rank and second-rank select fields: no reset, contents start undefined.
  always_ff @(posedge clk) begin
    if (stb.wrStb && stb.addrOk) begin
      selR1[idx] <= dataIn[SEL_W-1:0];
      enR1[idx]  <= dataIn[WORD_W-1];
    end
    if (stb.xferStb) selR2 <= selR1;
  end

  // Second-rank enables: the only storage the global reset touches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             enR2 <= '0;
    else if (stb.xferStb)  enR2 <= enR1;
  end

  always_comb begin
    rdWord = '0;
    if (stb.addrOk) rdWord = {enR2[idx], selR2[idx]};
  end

  assign dataOe  = stb.rdStb;
  assign dataOut = stb.rdStb ? rdWord : '0;
  assign selVec  = selR2;
  assign enVec   = enR2;

  for (genvar g = 0; g < NUM_OUT; g++) begin : gBad
    assign badSel[g] = (selR2[g] > MAX_SEL);
  end

  // R1
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && stb.addrOk) |=> ({enR1[$past(idx)], selR1[$past(idx)]} == $past(dataIn)));

  // R2
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.xferStb |=> (selR2 == $past(selR1)) && (enR2 == $past(enR1)));

  // R5
  rank2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.xferStb |=> $stable(selR2) && $stable(enR2));
endmodule

// File: rtl/xbar_cfg_port.sv
`timescale 1ns/1ps
module xbar_cfg_port #(
  parameter int NUM_OUT = 17,
  parameter int NUM_IN  = 33,
  parameter int ADDR_W  = 5,
  parameter int WORD_W  = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          weN,
  input  logic                          reN,
  input  logic                          updN,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_W-1:0]             dataIn,
  output logic [WORD_W-1:0]             dataOut,
  output logic                          dataOe,
  output logic [NUM_OUT*(WORD_W-1)-1:0] selVec,
  output logic [NUM_OUT-1:0]            enVec,
  output logic [NUM_OUT-1:0]            badSel
);
  localparam int SEL_W = WORD_W - 1;
  xcfg_pkg::cfgStrobes_t stb;

  xcfg_ctrl #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) ctrl (
    .csN(csN), .weN(weN), .reN(reN), .updN(updN), .addr(addr), .stb(stb)
  );

  xcfg_store #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) store (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .selVec(selVec), .enVec(enVec), .badSel(badSel)
  );

  // R5
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(selVec) && $stable(enVec));

  // R3
  rd_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && (32'(addr) < NUM_OUT)) |->
      (dataOut == {enVec[addr], selVec[addr*SEL_W +: SEL_W]}));
endmodule

// File: tb/xbar_cfg_port_test.sv
`timescale 1ns/1ps
module xbar_cfg_port_test;
  localparam int NO = 17;
  logic clk = 0, rstN = 0, csN = 1, weN = 1, reN = 1, updN = 1;
  logic [4:0] addr = '0;
  logic [6:0] dataIn = '0, dataOut;
  logic dataOe;
  logic [NO*6-1:0] selVec;
  logic [NO-1:0] enVec, badSel;
  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [6:0] expR1 [NO];
  logic [6:0] expR2 [NO];

  always #2.5 clk = ~clk;

  xbar_cfg_port uut (.clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .reN(reN), .updN(updN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .selVec(selVec), .enVec(enVec), .badSel(badSel));

  // {addr, word}; word = {enable, select[5:0]}
  localparam logic [11:0] VEC [6] = '{
    {5'd0, 7'b1_000101}, {5'd16, 7'b1_100000}, {5'd5, 7'b0_000111},
    {5'd9, 7'b1_101000}, {5'd1, 7'b1_000000}, {5'd12, 7'b0_111111}};

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    logic [NO*6-1:0] eSel;
    logic [NO-1:0] eEn, eBad;
    for (int i = 0; i < NO; i++) begin
      eSel[i*6 +: 6] = expR2[i][5:0];
      eEn[i] = expR2[i][6];
      eBad[i] = expR2[i][5:0] > 6'd32;
    end
    chk(selVec == eSel, {req, " selVec"}, 128'(selVec), 128'(eSel));
    chk(enVec == eEn, {req, " enVec"}, 128'(enVec), 128'(eEn));
    chk(badSel == eBad, {req, " badSel (R9)"}, 128'(badSel), 128'(eBad));
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [6:0] w, input bit cs);
    @(negedge clk); csN = !cs; weN = 0; addr = a; dataIn = w;
    @(negedge clk); csN = 1; weN = 1;
    if (cs && a < NO) expR1[a] = w;
  endtask

  task automatic doUpdate(input bit cs);
    @(negedge clk); csN = !cs; updN = 0;
    @(negedge clk); csN = 1; updN = 1;
    if (cs) for (int i = 0; i < NO; i++) expR2[i] = expR1[i];
  endtask

  task automatic readChk(input logic [4:0] a, input string req);
    logic [6:0] e;
    e = (a < NO) ? expR2[a] : 7'd0;
    @(negedge clk); csN = 0; reN = 0; addr = a; #1;
    chk(dataOe == 1'b1, {req, " dataOe on read"}, 128'(dataOe), 128'(1));
    chk(dataOut == e, {req, " readback word"}, 128'(dataOut), 128'(e));
    csN = 1; reN = 1; #1;
    chk(dataOe == 1'b0, "R3 dataOe released", 128'(dataOe), 128'(0));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // Reset state: R7 enables cleared without a clock edge, R3 bus idle
    #1;
    chk(enVec == '0, "R7 enVec in reset", 128'(enVec), 128'(0));
    chk(dataOe == 1'b0, "R3 dataOe idle", 128'(dataOe), 128'(0));
    repeat (3) @(negedge clk);
    rstN = 1;
    // Defined starting contents
    for (int i = 0; i < NO; i++) doWrite(5'(i), 7'd0, 1);
    doUpdate(1);
    checkAll("R2 cleared start");

    // Vector table: R1 writes invisible before update
    for (int v = 0; v < 6; v++) doWrite(VEC[v][11:7], VEC[v][6:0], 1);
    checkAll("R1 no effect before update");
    doUpdate(1);
    checkAll("R2 R8 after update");
    for (int v = 0; v < 6; v++) readChk(VEC[v][11:7], "R3");

    // R6 out-of-range address
    doWrite(5'd20, 7'b1_000011, 1);
    doWrite(5'd31, 7'b1_000011, 1);
    doUpdate(1);
    checkAll("R6 out-of-range write");
    readChk(5'd20, "R6");

    // R5 chip select high blocks write and update
    doWrite(5'd3, 7'b1_001010, 0);
    doUpdate(1);
    checkAll("R5 write with cs high");
    doWrite(5'd3, 7'b1_001010, 1);
    doUpdate(0);
    checkAll("R5 update with cs high");
    doUpdate(1);
    checkAll("R2 update after cs test");

    // R2 write and update on the same edge: copy uses old first rank
    @(negedge clk); csN = 0; weN = 0; updN = 0; addr = 5'd7; dataIn = 7'b1_010001;
    @(negedge clk); csN = 1; weN = 1; updN = 1;
    for (int i = 0; i < NO; i++) expR2[i] = expR1[i];
    expR1[7] = 7'b1_010001;
    checkAll("R2 simultaneous write+update");
    doUpdate(1);
    checkAll("R2 second update exposes write");

    // R4 read and write together
    @(negedge clk); csN = 0; weN = 0; reN = 0; addr = 5'd0; dataIn = 7'b0_011111; #1;
    chk(dataOut == expR2[0], "R4 readback during write", 128'(dataOut), 128'(expR2[0]));
    @(negedge clk); #1;
    chk(dataOut == expR2[0], "R4 readback after write", 128'(dataOut), 128'(expR2[0]));
    csN = 1; weN = 1; reN = 1;
    expR1[0] = 7'b0_011111;

    // R7 reset with cs high, between edges
    @(negedge clk); #1; rstN = 0; #1;
    for (int i = 0; i < NO; i++) expR2[i][6] = 1'b0;
    checkAll("R7 async enable clear");
    repeat (2) @(negedge clk);
    rstN = 1;
    checkAll("R7 after release");
    doUpdate(1);
    checkAll("R7 first rank kept");
    readChk(5'd16, "R3 after reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule